// File: doc/BRIEF.md
# Serial Register Port with Bidirectional Data Line

This block is the control-side slave of a three-wire serial link: a frame enable, a serial clock and one data line that the master and the slave share. It owns a small register file whose contents drive the rest of the chip. The master writes a register by sending an 8-bit address and then 8 data bits, least significant bit first. It reads one by sending an address with the direction bit set, giving two idle clocks, and then clocking the data back out of the slave.

All three serial inputs are brought into the system clock domain through synchroniser chains. Edges of the serial clock and of the enable are detected there, so the system clock must run several times faster than the serial clock. Registers 0 to 10 hold control settings. Address 15 is a read-only identity register. The data line is given as a separate input, output and output enable, and the pad cell joins them.

Top module: `serial_reg_port`

## Requirements
- R1: During and after a synchronous active-low reset, every control register is zero and `sdata_oe` is low.
- R2: While `sen` is high, `sdata_in` is sampled on each rising `sclk` edge. The first 8 bits are the address, bit a0 first. Bits a5..a0 select the register and a6 is ignored. If a7 = 0 the frame is a write. Its data byte (d0 first) is stored in the selected register when `sen` falls, and it appears on `regs_flat[8*n +: 8]` for register n.
- R3: If more than 16 bits are clocked in a write frame, the register receives the last 8 bits before `sen` falls.
- R4: A write frame that ends with fewer than 16 bits changes no register. So does any frame that ends with fewer than 8 bits.
- R5: If a7 = 1 the frame is a read and changes no register. After the 8th rising edge, two more rising edges pass as wait cycles. Bit d0 of the selected register is then driven on the next falling edge, and d1..d7 follow on the following falling edges. `sdata_oe` rises with d0 and falls on the falling edge after d7.
- R6: If `sen` falls during a read, `sdata_oe` goes low within a few system clocks and stays low while `sen` is low.
- R7: A read of address 15 returns 0x03, and writes to it are discarded. Writes to addresses 11..63 other than 15 are discarded, and reads of those addresses return 0x00.
- R8: While `sen` is low, activity on `sclk` and `sdata_in` changes no register and does not drive the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sen | input | 1 | Frame enable, high while a frame is in progress |
| sclk | input | 1 | Serial clock from the master |
| sdata_in | input | 1 | Data line as seen by the receiver |
| sdata_out | output | 1 | Value the slave drives onto the data line |
| sdata_oe | output | 1 | Drive enable for the data line |
| regs_flat | output | 88 | Control registers 0..10, 8 bits each, register n at bits 8n+7..8n |

## Verification
The hardest situations to reach are the ones defined by where a frame stops, not by what it carries. These are a read cut off partway through its output bits, a write one bit short of complete, and a write that keeps clocking past 16 bits. The bench drives every frame from a bit stream with an explicit bit count, so each of these endings is an ordinary call with a different count. It samples the data line at the end of every serial low phase, and it compares the whole register bus with a behavioural model on every system clock once a frame has settled.

// File: rtl/sport_pkg.sv
// Shared sizes and types for the serial register port.
// Assumes an 8-bit address and 8-bit data frame, sent LSB first.
package sport_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int SEL_W     = 6;
    localparam int FRAME_W   = ADDR_W + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_W + 1);
    localparam int WAIT_RISE = 2;

    typedef enum logic [2:0] {
        ST_ADDR,
        ST_WDATA,
        ST_RWAIT,
        ST_ROUT,
        ST_DONE
    } frame_state_t;
endpackage

// File: rtl/sport_sync.sv
// Multi-stage synchroniser for a vector of independent asynchronous inputs.
// Assumes each bit is a slow level and needs no relation to the other bits.
module sport_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw input through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], async_in[g]};
        end

        assign sync_out[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/sport_frame.sv
// Frame engine: collects the address and data bits, decodes the direction,
// raises a write strobe when the enable falls, and serialises read data.
// Assumes the edge strobes are one system clock wide and never coincide.
module sport_frame
    import sport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sen_lvl,
    input  logic              sen_fall,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din,
    input  logic [DATA_W-1:0] rd_data,
    output logic [SEL_W-1:0]  sel,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_en
);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] SEL_BITS  = CNT_W'(SEL_W);
    localparam logic [1:0]       WAIT_END  = 2'(WAIT_RISE);
    localparam logic [3:0]       OUT_END   = 4'(DATA_W);

    frame_state_t      state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [1:0]        wait_cnt;
    logic [3:0]        out_cnt;
    logic [DATA_W-1:0] shreg;

    // Sequence one frame: address, then write data or read output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_ADDR;
            bit_cnt  <= '0;
            wait_cnt <= '0;
            out_cnt  <= '0;
            shreg    <= '0;
            sel      <= '0;
            wr_data  <= '0;
            wr_stb   <= 1'b0;
            sdo      <= 1'b0;
            sdo_en   <= 1'b0;
        end else if (!sen_lvl) begin
            wr_stb   <= sen_fall && (state == ST_WDATA) && (bit_cnt == FULL_CNT);
            state    <= ST_ADDR;
            bit_cnt  <= '0;
            wait_cnt <= '0;
            out_cnt  <= '0;
            sdo_en   <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            unique case (state)
                ST_ADDR: if (sclk_rise) begin
                    if (bit_cnt < SEL_BITS) sel <= {din, sel[SEL_W-1:1]};
                    bit_cnt <= bit_cnt + CNT_W'(1);
                    if (bit_cnt == LAST_ADDR) begin
                        if (din) begin
                            shreg    <= rd_data;
                            wait_cnt <= '0;
                            state    <= ST_RWAIT;
                        end else begin
                            state <= ST_WDATA;
                        end
                    end
                end
                ST_WDATA: if (sclk_rise) begin
                    wr_data <= {din, wr_data[DATA_W-1:1]};
                    if (bit_cnt != FULL_CNT) bit_cnt <= bit_cnt + CNT_W'(1);
                end
                ST_RWAIT: begin
                    if (sclk_rise && wait_cnt != WAIT_END) wait_cnt <= wait_cnt + 2'd1;
                    if (sclk_fall && wait_cnt == WAIT_END) begin
                        sdo     <= shreg[0];
                        shreg   <= {1'b0, shreg[DATA_W-1:1]};
                        sdo_en  <= 1'b1;
                        out_cnt <= 4'd1;
                        state   <= ST_ROUT;
                    end
                end
                ST_ROUT: if (sclk_fall) begin
                    if (out_cnt == OUT_END) begin
                        sdo_en <= 1'b0;
                        state  <= ST_DONE;
                    end else begin
                        sdo     <= shreg[0];
                        shreg   <= {1'b0, shreg[DATA_W-1:1]};
                        out_cnt <= out_cnt + 4'd1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sport_regfile.sv
// Control register file with a read-only identity location.
// Assumes a write strobe lasts one cycle and the selection is steady while it is high.
module sport_regfile
    import sport_pkg::*;
#(
    parameter int              NUM_REGS = 11,
    parameter int              ID_SEL   = 15,
    parameter logic [DATA_W-1:0] ID_VAL = 8'h03
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_stb,
    input  logic [SEL_W-1:0]           sel,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // Hold one control byte and load it on a matching write strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)                            regs_flat[i*DATA_W +: DATA_W] <= '0;
            else if (wr_stb && sel == SEL_W'(i))   regs_flat[i*DATA_W +: DATA_W] <= wr_data;
        end
    end

    // Select the byte that a read returns; unknown locations give zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (sel == SEL_W'(i)) rd_data = regs_flat[i*DATA_W +: DATA_W];
        if (sel == SEL_W'(ID_SEL)) rd_data = ID_VAL;
    end
endmodule

// File: rtl/serial_reg_port.sv
// Top of the serial register port: synchronises the three serial inputs,
// detects their edges, and joins the frame engine to the register file.
// Assumes clk runs at least several times faster than sclk.
module serial_reg_port
    import sport_pkg::*;
#(
    parameter int NUM_REGS    = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sen,
    input  logic                       sclk,
    input  logic                       sdata_in,
    output logic                       sdata_out,
    output logic                       sdata_oe,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    logic [2:0]        lvl;
    logic              sen_lvl, sclk_lvl, din_lvl;
    logic              sen_prev, sclk_prev;
    logic              sen_fall, sclk_rise, sclk_fall;
    logic              wr_stb;
    logic [SEL_W-1:0]  wr_sel;
    logic [DATA_W-1:0] wr_data, rd_data;

    sport_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({sdata_in, sclk, sen}),
        .sync_out(lvl)
    );

    assign sen_lvl  = lvl[0];
    assign sclk_lvl = lvl[1];
    assign din_lvl  = lvl[2];

    // Remember last levels of enable and serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sen_prev  <= 1'b0;
            sclk_prev <= 1'b0;
        end else begin
            sen_prev  <= sen_lvl;
            sclk_prev <= sclk_lvl;
        end
    end

    assign sen_fall  = sen_prev & ~sen_lvl;
    assign sclk_rise = sen_lvl & sclk_lvl & ~sclk_prev;
    assign sclk_fall = sen_lvl & ~sclk_lvl & sclk_prev;

    sport_frame u_frame (
        .clk(clk), .rst_n(rst_n),
        .sen_lvl(sen_lvl), .sen_fall(sen_fall),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .din(din_lvl), .rd_data(rd_data),
        .sel(wr_sel), .wr_stb(wr_stb), .wr_data(wr_data),
        .sdo(sdata_out), .sdo_en(sdata_oe)
    );

    sport_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(wr_stb), .sel(wr_sel), .wr_data(wr_data),
        .rd_data(rd_data), .regs_flat(regs_flat)
    );
endmodule

// File: rtl/serial_reg_port_chk.sv
// Protocol checker for the serial register port, attached by bind.
// Assumes it sees the internal enable level, edge strobes and write strobe.
module serial_reg_port_chk #(
    parameter int NUM_REGS = 11
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sen_lvl,
    input logic                  sen_fall,
    input logic                  sclk_fall,
    input logic                  wr_stb,
    input logic [5:0]            wr_sel,
    input logic                  sdata_oe,
    input logic [NUM_REGS*8-1:0] regs_flat
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (regs_flat == '0 && !sdata_oe));

    // R2
    commit_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (!sen_lvl && $past(sen_fall)));

    // R4
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stb) |-> $stable(regs_flat));

    // R5
    oe_start_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdata_oe) |-> $past(sclk_fall));

    // R6
    oe_off_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sen_lvl && !sen_fall) |-> !sdata_oe);

    // R7
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_sel >= 6'(NUM_REGS)) |=> $stable(regs_flat));
endmodule

bind serial_reg_port serial_reg_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .sen_lvl(sen_lvl), .sen_fall(sen_fall),
    .sclk_fall(sclk_fall), .wr_stb(wr_stb), .wr_sel(wr_sel),
    .sdata_oe(sdata_oe), .regs_flat(regs_flat)
);

// File: tb/test_serial_reg_port.sv
`timescale 1ns/1ps
module test_serial_reg_port;
    localparam int NREG = 11;
    localparam int HALF = 8;

    logic clk = 1'b0, rst_n = 1'b0, sen = 1'b0, sclk = 1'b0, sdata_in = 1'b0;
    logic sdata_out, sdata_oe;
    logic [NREG*8-1:0] regs_flat;

    int   checks = 0, errors = 0;
    logic [7:0] model [0:63];
    bit   settled = 1'b0;
    logic smp_d [0:63];
    logic smp_oe [0:63];
    logic end_oe;

    serial_reg_port i_serial_reg_port (
        .clk(clk), .rst_n(rst_n), .sen(sen), .sclk(sclk), .sdata_in(sdata_in),
        .sdata_out(sdata_out), .sdata_oe(sdata_oe), .regs_flat(regs_flat)
    );

    always #2 clk = ~clk;

    function automatic logic [NREG*8-1:0] packed_model();
        logic [NREG*8-1:0] p;
        for (int i = 0; i < NREG; i++) p[i*8 +: 8] = model[i];
        return p;
    endfunction

    function automatic logic [7:0] expect_read(input logic [7:0] a);
        int s = int'(a[5:0]);
        if (s < NREG) return model[s];
        if (s == 15)  return 8'h03;
        return 8'h00;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference comparison on every clock once a frame has settled (R2, R6, R8).
    always @(negedge clk) begin
        if (settled) begin
            checks++;
            if (regs_flat !== packed_model() || sdata_oe !== 1'b0) begin
                errors++;
                $display("FAIL R2: regs %h oe %b expected %h oe 0",
                         regs_flat, sdata_oe, packed_model());
            end
        end
    end

    task automatic clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Clock n bits of s (LSB first) with sen high; record the line before each rise.
    task automatic xfer(input logic [63:0] s, input int n, input bit use_sen);
        settled = 1'b0;
        sen = use_sen;
        clks(HALF);
        for (int k = 0; k < n; k++) begin
            sdata_in = s[k];
            clks(HALF);
            smp_d[k]  = sdata_out;
            smp_oe[k] = sdata_oe;
            sclk = 1'b1;
            clks(HALF);
            sclk = 1'b0;
        end
        clks(HALF);
        end_oe = sdata_oe;
        sen = 1'b0;
        sdata_in = 1'b0;
        clks(HALF);
        if (use_sen && n >= 16 && s[7] == 1'b0 && int'(s[5:0]) < NREG)
            model[int'(s[5:0])] = s[n-8 +: 8];
        settled = 1'b1;
        clks(2);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        xfer({48'd0, d, a & 8'h7f}, 16, 1'b1);
    endtask

    // Full read with two wait cycles and eight output bits (R5).
    task automatic rd(input logic [7:0] a, input string req);
        logic [7:0] got;
        logic [7:0] exp = expect_read(a);
        xfer({56'd0, a | 8'h80}, 18, 1'b1);
        for (int b = 0; b < 8; b++) got[b] = smp_d[10 + b];
        chk(req, got, exp);
        chk("R5 oe low in wait", smp_oe[9], 0);
        chk("R5 oe high d0", smp_oe[10], 1);
        chk("R5 oe high d7", smp_oe[17], 1);
        chk("R5 oe low after d7", end_oe, 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        clks(5);
        // R1: reset state
        chk("R1 regs", int'(regs_flat == '0), 1);
        chk("R1 oe", sdata_oe, 0);
        rst_n = 1'b1;
        clks(4);
        settled = 1'b1;
        rd(8'h00, "R1 read reg0");

        // R2: basic write and readback, a6 ignored
        wr(8'h03, 8'hA5);
        rd(8'h03, "R2 reg3");
        wr(8'h47, 8'h3C);
        rd(8'h07, "R2 a6 ignored");
        for (int i = 0; i < NREG; i++) wr(8'(i), 8'(8'h91 + 8'(i * 37)));
        for (int i = 0; i < NREG; i++) rd(8'(i), "R2 sweep");

        // R3: longer write keeps last 8 bits
        xfer({40'd0, 8'h9E, 8'h11, 8'h02}, 24, 1'b1);
        rd(8'h02, "R3 long write");

        // R4: short frames change nothing
        xfer({48'd0, 8'h55, 8'h03}, 15, 1'b1);
        rd(8'h03, "R4 15-bit write");
        xfer({59'd0, 5'h04}, 5, 1'b1);
        rd(8'h04, "R4 5-bit frame");

        // R7: identity register and unmapped locations
        rd(8'h8F, "R7 id");
        wr(8'h0F, 8'hFF);
        rd(8'h0F, "R7 id after write");
        wr(8'h14, 8'h77);
        rd(8'h14, "R7 unmapped read");
        rd(8'h2F, "R7 sel 47");

        // R5: long read frame writes nothing
        xfer({48'd0, 8'hEE, 8'h85}, 24, 1'b1);
        rd(8'h05, "R5 read no write");

        // R6: read interrupted after three bits
        xfer({56'd0, 8'h86}, 13, 1'b1);
        chk("R6 d0", smp_d[10], int'(model[6][0]));
        chk("R6 d2", smp_d[12], int'(model[6][2]));
        chk("R6 oe after abort", sdata_oe, 0);

        // R8: activity with enable low
        xfer({48'd0, 8'h00, 8'h01}, 16, 1'b0);
        chk("R8 oe", sdata_oe, 0);
        rd(8'h01, "R8 reg1 unchanged");

        clks(20);
        finish_run();
    end
endmodule